// File: doc/BRIEF.md
# Selectable Clock Observation Divider

This block puts one of sixteen internal clocks onto a single observation pin. A 4-bit selector picks the source, a per-source 3-bit divider field sets a ratio from 1 to 8, and a gate bit either passes the divided clock or holds the pin low. A few reference sources have no divider field and always pass through undivided. Two source slots are empty and always give a low output.

Software programs three 32-bit registers through a simple write strobe and a combinational read port. The recommended order is to clear the gate, pick the source, set the divider fields, and then set the gate. In this model the source clocks are level signals sampled by the block clock. All output changes occur on that clock, so the observed waveform is one block-clock cycle behind the sampled source.

Top module: `clkmon_div`

## Requirements
- R1: After reset all three registers read zero and `clk_out` is low.
- R2: The control register is at byte offset 0x74 and holds the selector in bits [3:0] and the gate in bit 4. The first divider register is at 0x78 and the second is at 0x7C. Each divider field is 3 bits wide and starts at a multiple of 4. Bits outside the fields read zero. Any other offset reads zero, and writes to it change nothing.
- R3: While the gate bit is 0, `clk_out` is low.
- R4: Selector values 2 and 3 give a constant-low `clk_out` even with the gate set.
- R5: Selector values 0, 1 and 4 pass the selected input through at ratio 1, whatever the divider registers hold.
- R6: The divider field for each selector value is as follows. First register: value 5 uses offset 0, value 6 uses offset 4, value 9 uses offset 8, value 7 uses offset 12, value 8 uses offset 16 and value 10 uses offset 20. Second register: value 11 uses offset 0, value 12 uses offset 4, value 13 uses offset 8, value 15 uses offset 12 and value 14 uses offset 16.
- R7: A field value F gives ratio N = F+1. Once the gate is on, `clk_out` stays low until the first rising edge of the selected input. Each output period then starts high at an input rising edge. The high phase lasts ceil(N/2) input cycles and the low phase lasts floor(N/2) input cycles. At ratio 1 the output follows the sampled input.
- R8: A new divider field value is used only from the next output period boundary. The period in progress completes with the old ratio.
- R9: A control write that keeps an already set gate bit set leaves the selector unchanged. Any other control write loads the selector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; samples the sources and registers |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| src_clk | input | 16 | Source clock levels, one per selector value |
| clk_out | output | 1 | Gated, divided observation clock |

## Verification
The bench sweeps every selector value against every divider ratio. It catches a wrong ceil/floor split of odd ratios, which would show up as a high phase that is too short or too long. A distinct value in each field exposes a swapped field offset, for example between values 14 and 15, because the swapped slot would run at another slot's ratio. A divider write in the middle of a period shows whether the block cuts the period short, which would produce a runt pulse. Further checks cover the selector being held while the gate stays on and the empty slots staying low; a design that got these wrong would drive the wrong source onto the pin.

// File: rtl/clkmon_div.sv
module clkmon_div #(
  parameter int AW = 8,
  parameter int DW = 32,
  parameter int NSRC = 16,
  parameter int SELW = 4,
  parameter int FW = 3,
  parameter logic [AW-1:0] CFG_OFS = 8'h74,
  parameter logic [AW-1:0] DIVA_OFS = 8'h78,
  parameter logic [AW-1:0] DIVB_OFS = 8'h7C,
  parameter logic [DW-1:0] DIVA_MASK = 32'h0077_7777,
  parameter logic [DW-1:0] DIVB_MASK = 32'h0007_7777
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic [AW-1:0]   reg_addr,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  input  logic [NSRC-1:0] src_clk,
  output logic            clk_out
);
  localparam int GATE_BIT = SELW;

  logic [SELW-1:0] sel_q;
  logic            gate_q;
  logic [DW-1:0]   diva_q, divb_q;
  logic [NSRC-1:0] src_q;
  logic [FW-1:0]   cnt_q, ratio_q, fld;
  logic            run_q, div_q;
  logic            populated, rise, bound;
  logic [FW:0]     half, cnt_nx;

  always_comb begin
    case (sel_q)
      4'd5:    fld = diva_q[2:0];
      4'd6:    fld = diva_q[6:4];
      4'd9:    fld = diva_q[10:8];
      4'd7:    fld = diva_q[14:12];
      4'd8:    fld = diva_q[18:16];
      4'd10:   fld = diva_q[22:20];
      4'd11:   fld = divb_q[2:0];
      4'd12:   fld = divb_q[6:4];
      4'd13:   fld = divb_q[10:8];
      4'd15:   fld = divb_q[14:12];
      4'd14:   fld = divb_q[18:16];
      default: fld = '0;
    endcase
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == CFG_OFS)       reg_rdata[GATE_BIT:0] = {gate_q, sel_q};
    else if (reg_addr == DIVA_OFS) reg_rdata = diva_q;
    else if (reg_addr == DIVB_OFS) reg_rdata = divb_q;
  end

  assign populated = (sel_q != 4'd2) && (sel_q != 4'd3);
  assign rise      = src_clk[sel_q] & ~src_q[sel_q];
  assign bound     = rise && (!run_q || cnt_q == ratio_q);
  assign half      = ({1'b0, ratio_q} + 2) >> 1;
  assign cnt_nx    = {1'b0, cnt_q} + 1;
  assign clk_out   = gate_q && populated && run_q &&
                     ((ratio_q == '0) ? src_q[sel_q] : div_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q   <= '0;
      gate_q  <= 1'b0;
      diva_q  <= '0;
      divb_q  <= '0;
      src_q   <= '0;
      cnt_q   <= '0;
      ratio_q <= '0;
      run_q   <= 1'b0;
      div_q   <= 1'b0;
    end else begin
      src_q <= src_clk;
      if (reg_wr) begin
        if (reg_addr == CFG_OFS) begin
          if (!(gate_q && reg_wdata[GATE_BIT])) sel_q <= reg_wdata[SELW-1:0];
          gate_q <= reg_wdata[GATE_BIT];
        end
        if (reg_addr == DIVA_OFS) diva_q <= reg_wdata & DIVA_MASK;
        if (reg_addr == DIVB_OFS) divb_q <= reg_wdata & DIVB_MASK;
      end
      if (!gate_q) begin
        run_q   <= 1'b0;
        cnt_q   <= '0;
        ratio_q <= '0;
        div_q   <= 1'b0;
      end else if (bound) begin
        run_q   <= 1'b1;
        cnt_q   <= '0;
        ratio_q <= fld;
        div_q   <= 1'b1;
      end else if (rise) begin
        cnt_q <= cnt_nx[FW-1:0];
        div_q <= cnt_nx < half;
      end
    end
  end

  a_r3_gate_low: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_q |-> !clk_out);
  a_r4_empty_slot_low: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q == 4'd2 || sel_q == 4'd3) |-> !clk_out);
  a_r7_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= ratio_q);
  a_r7_period_starts_high: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_q && bound) |=> div_q);
  a_r8_ratio_held: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_q && run_q && !bound) |=> $stable(ratio_q));
  a_r9_sel_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_q && $past(gate_q)) |-> $stable(sel_q));
endmodule

// File: tb/sim_clkmon_div.sv
module sim_clkmon_div;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        reg_wr = 0;
  logic [7:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic [15:0] src_clk = 0;
  logic        clk_out;

  clkmon_div u0 (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
                 .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_clk(src_clk),
                 .clk_out(clk_out));

  always #5 clk = ~clk;

  int total = 0, bad = 0, g = 0;
  bit done = 0;
  logic [15:0] prev = 0;
  bit  m_gate = 0, started = 0, chk_en = 0;
  int  m_sel = 0, pos = 0, nact = 1;
  logic [31:0] m_a = 0, m_b = 0;

  function automatic logic srcval(int i, int t);
    return ((t / (1 + i % 4)) % 2) == 1;
  endfunction

  function automatic int field(int s, logic [31:0] a, logic [31:0] b);
    case (s)
      5: return int'((a >> 0) & 7);
      6: return int'((a >> 4) & 7);
      9: return int'((a >> 8) & 7);
      7: return int'((a >> 12) & 7);
      8: return int'((a >> 16) & 7);
      10: return int'((a >> 20) & 7);
      11: return int'((b >> 0) & 7);
      12: return int'((b >> 4) & 7);
      13: return int'((b >> 8) & 7);
      15: return int'((b >> 12) & 7);
      14: return int'((b >> 16) & 7);
      default: return 0;
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(string tag);
    logic [15:0] cur;
    logic expv;
    @(posedge clk);
    #2;
    cur = src_clk;
    if (rst_n) begin
      if (m_gate) begin
        if (cur[m_sel] && !prev[m_sel]) begin
          if (!started || pos == nact - 1) begin
            pos = 0; nact = field(m_sel, m_a, m_b) + 1; started = 1;
          end else pos++;
        end
      end else begin
        started = 0; pos = 0; nact = 1;
      end
      if (reg_wr) begin
        if (reg_addr == 8'h74) begin
          if (!(m_gate && reg_wdata[4])) m_sel = int'(reg_wdata[3:0]);
          m_gate = reg_wdata[4];
        end
        if (reg_addr == 8'h78) m_a = reg_wdata & 32'h0077_7777;
        if (reg_addr == 8'h7C) m_b = reg_wdata & 32'h0007_7777;
      end
    end
    prev = cur;
    if (!m_gate || m_sel == 2 || m_sel == 3 || !started) expv = 0;
    else if (nact == 1) expv = cur[m_sel];
    else expv = (pos < (nact + 1) / 2);
    if (chk_en) check(tag, {31'b0, clk_out}, {31'b0, expv});
    reg_wr = 0;
    g++;
    for (int i = 0; i < 16; i++) src_clk[i] = srcval(i, g);
  endtask

  task automatic wreg(logic [7:0] a, logic [31:0] d, string tag);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    cyc(tag);
  endtask

  task automatic rchk(logic [7:0] a, logic [31:0] exp, string tag);
    reg_addr = a;
    #1;
    check(tag, reg_rdata, exp);
  endtask

  task automatic run(int n, string tag);
    for (int i = 0; i < n; i++) cyc(tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    run(3, "R1");
    rst_n = 1;
    chk_en = 1;
    // R1 reset state
    rchk(8'h74, 0, "R1"); rchk(8'h78, 0, "R1"); rchk(8'h7C, 0, "R1");
    run(4, "R1");
    // R2 register map and masks
    wreg(8'h78, 32'hFFFF_FFFF, "R2");
    wreg(8'h7C, 32'hFFFF_FFFF, "R2");
    wreg(8'h74, 32'hFFFF_FFE5, "R2");
    rchk(8'h78, 32'h0077_7777, "R2");
    rchk(8'h7C, 32'h0007_7777, "R2");
    rchk(8'h74, 32'h0000_0005, "R2");
    wreg(8'h70, 32'hFFFF_FFFF, "R2");
    rchk(8'h70, 0, "R2");
    rchk(8'h74, 32'h0000_0005, "R2");
    rchk(8'h80, 0, "R2");
    // R9 selector locked while gate stays on
    wreg(8'h74, 32'h15, "R9");
    wreg(8'h74, 32'h13, "R9");
    rchk(8'h74, 32'h15, "R9");
    run(20, "R9");
    wreg(8'h74, 32'h03, "R9");
    rchk(8'h74, 32'h03, "R9");
    // R3 gate off keeps output low while a divided source is selected
    wreg(8'h74, 32'h07, "R3");
    run(30, "R3");
    // full sweep: every slot, every ratio
    for (int f = 0; f < 8; f++) begin
      wreg(8'h78, 32'h0011_1111 * f, "R7");
      wreg(8'h7C, 32'h0001_1111 * f, "R7");
      for (int s = 0; s < 16; s++) begin
        string tg;
        tg = (s == 2 || s == 3) ? "R4" : (s == 0 || s == 1 || s == 4) ? "R5" : "R7";
        wreg(8'h74, 32'h0, tg);
        wreg(8'h74, 32'h10 | s, tg);
        run(40, tg);
      end
    end
    // R6 distinct value per field
    wreg(8'h74, 32'h0, "R6");
    wreg(8'h78, 32'h0076_5432, "R6");
    wreg(8'h7C, 32'h0006_5431, "R6");
    for (int s = 5; s < 16; s++) begin
      wreg(8'h74, 32'h0, "R6");
      wreg(8'h74, 32'h10 | s, "R6");
      run(50, "R6");
    end
    // R8 ratio change mid-period on slot 7 (first register, offset 12)
    wreg(8'h74, 32'h0, "R8");
    wreg(8'h78, 32'h0000_2000, "R8");
    wreg(8'h74, 32'h17, "R8");
    run(17, "R8");
    wreg(8'h78, 32'h0000_5000, "R8");
    run(60, "R8");
    wreg(8'h78, 32'h0000_0000, "R8");
    run(40, "R8");
    // R3 gate cleared while running
    wreg(8'h74, 32'h07, "R3");
    run(20, "R3");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule